// File: doc/BRIEF.md
# Paged MDIO Register Access Sequencer

This engine sits on the host side of a management link to an Ethernet switch. Software-style 32-bit accesses to a flat switch register space come in on a valid/ready command port. The engine breaks each one into a sequence of 16-bit MDIO read and write requests and hands them to a downstream MDIO frame master over a request/acknowledge handshake. When an access falls into a different page of the register space, the engine first writes a page-select register and waits for it to settle. It remembers the last page written, so accesses within the same page need no page write.

Eight operations are supported. Whole-word read and write, low or high half-word read and write, read-modify-write, and poll-until-match with a bounded retry count. A configuration input picks the order in which the two halves of a word are written. Only one command is in flight at a time. Each command ends with a single-cycle response that carries the read data and an error flag. All microsecond delays are expressed in cycles through the `CLK_PER_US` parameter.

Top module: `paged_mdio_seq`

## Requirements
- R1: After reset `cmd_ready_o` is 1 and `rsp_valid_o` and `mdio_req_o` are 0. The page cache starts invalid, so the first command always writes the page, even for page 0.
- R2: The command address splits into page = addr[17:9], select = addr[8:6] and register = addr[5:1]. When the page differs from the cached page, the engine first writes the page value to MDIO PHY 0x18, register 0. When the page matches, that write is skipped.
- R3: After the page write is acknowledged, no further MDIO request starts for at least PAGE_SETTLE_US*CLK_PER_US cycles.
- R4: Data requests use PHY address 0x10 OR the 3-bit select, and the register from addr[5:1]. Command addresses are half-word aligned, so addr[0] is 0.
- R5: Op code 0 (whole read) reads register N, then register N+1, and returns {second, first}.
- R6: Op code 1 (whole write) writes both halves. With `lo_first_i`=1 (sampled at acceptance), the order is low to N, then high to N+1. With 0, the order is high to N+1, then low to N.
- R7: Op codes 2 and 4 read and write the low half at register N. Op codes 3 and 5 use address+2 (register N+1). A high read returns data in [31:16] with [15:0] zero, and a high write sends wdata[31:16].
- R8: Op code 6 reads the word and writes back (value & ~mask) | set, in the configured half order.
- R9: Op code 7 reads the word and finishes with error 0 once (value & mask) == set, returning the matching value. Between attempts it waits at least CLK_PER_US cycles.
- R10: With op code 7 and timeout T, a poll that never matches makes T+1 attempts and finishes with error 1.
- R11: `cmd_ready_o` is low from acceptance until the one-cycle `rsp_valid_o` pulse. A new command can then be accepted.
- R12: Each MDIO request holds its fields stable until acknowledged, and read data is taken on the acknowledge.
- R13: An error from the MDIO master on any request of a command sets `rsp_err_o` for that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lo_first_i | input | 1 | Half order for word writes: 1 = low half first |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Engine idle, command accepted when valid |
| cmd_op_i | input | 3 | Operation code |
| cmd_addr_i | input | 18 | Switch register byte address |
| cmd_wdata_i | input | 32 | Write data |
| cmd_mask_i | input | 32 | Mask for read-modify-write and poll |
| cmd_set_i | input | 32 | Set bits for read-modify-write, match value for poll |
| cmd_timeout_i | input | 16 | Poll retry count |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Error flag |
| mdio_req_o | output | 1 | MDIO request |
| mdio_we_o | output | 1 | MDIO request is a write |
| mdio_phy_o | output | 5 | MDIO PHY address |
| mdio_reg_o | output | 5 | MDIO register number |
| mdio_wdata_o | output | 16 | MDIO write data |
| mdio_ack_i | input | 1 | MDIO request done |
| mdio_rdata_i | input | 16 | MDIO read data, valid with acknowledge |
| mdio_err_i | input | 1 | MDIO error, valid with acknowledge |

## Verification
The assertions check the handshake rules on every cycle. They cover the ready drop on acceptance, the single-cycle response, the request fields held stable until acknowledged, page writes going only to register 0, half-word alignment, and the settle/gap timer reloading when started. Only the bench scenarios can show the results of each command. These are the page-write-or-skip decision and its settle length, the half order for each write mode, the masked merge, the poll match and its attempt count, and error propagation. The bench shows them by logging every MDIO transaction against a model of the switch register space.

// File: rtl/mdio_seq_pkg.sv
package mdio_seq_pkg;

  typedef enum logic [2:0] {
    OP_RD32    = 3'd0,
    OP_WR32    = 3'd1,
    OP_RD16_LO = 3'd2,
    OP_RD16_HI = 3'd3,
    OP_WR16_LO = 3'd4,
    OP_WR16_HI = 3'd5,
    OP_RMW     = 3'd6,
    OP_POLL    = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PAGE,
    S_SETTLE,
    S_RD0,
    S_RD1,
    S_RD16,
    S_WR0,
    S_WR1,
    S_WR16,
    S_GAP,
    S_RSP
  } state_e;

  localparam logic [4:0] PAGE_PHY      = 5'h18;
  localparam logic [4:0] DATA_PHY_BASE = 5'h10;

endpackage

// File: rtl/mdio_addr_map.sv
module mdio_addr_map
  import mdio_seq_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int SEL_W  = 3,
  parameter int REG_W  = 5
) (
  input  logic [PAGE_W+SEL_W+REG_W-1:0] waddr_i,  // half-word address (byte addr >> 1)
  input  logic                          hi_i,     // select upper half: +2 bytes
  output logic [PAGE_W-1:0]             page_o,
  output logic [4:0]                    phy_o,
  output logic [REG_W-1:0]              reg_o
);
  localparam int W = PAGE_W + SEL_W + REG_W;

  logic [W-1:0] eff;

  always_comb begin
    eff    = waddr_i + W'(hi_i);
    reg_o  = eff[REG_W-1:0];
    page_o = eff[W-1 -: PAGE_W];
    phy_o  = DATA_PHY_BASE | 5'(eff[REG_W +: SEL_W]);
  end

endmodule

// File: rtl/mdio_wait_timer.sv
module mdio_wait_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R3
  timer_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && len_i != '0) |=> !expired_o);

endmodule

// File: rtl/paged_mdio_seq.sv
module paged_mdio_seq
  import mdio_seq_pkg::*;
#(
  parameter int CLK_PER_US     = 125,
  parameter int PAGE_SETTLE_US = 2000,
  parameter int POLL_GAP_US    = 1,
  parameter int PAGE_W         = 9,
  parameter int SEL_W          = 3,
  parameter int REG_W          = 5,
  parameter int DATA_W         = 32,
  parameter int TMO_W          = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            lo_first_i,
  input  logic                            cmd_valid_i,
  output logic                            cmd_ready_o,
  input  logic [2:0]                      cmd_op_i,
  input  logic [PAGE_W+SEL_W+REG_W:0]     cmd_addr_i,
  input  logic [DATA_W-1:0]               cmd_wdata_i,
  input  logic [DATA_W-1:0]               cmd_mask_i,
  input  logic [DATA_W-1:0]               cmd_set_i,
  input  logic [TMO_W-1:0]                cmd_timeout_i,
  output logic                            rsp_valid_o,
  output logic [DATA_W-1:0]               rsp_rdata_o,
  output logic                            rsp_err_o,
  output logic                            mdio_req_o,
  output logic                            mdio_we_o,
  output logic [4:0]                      mdio_phy_o,
  output logic [REG_W-1:0]                mdio_reg_o,
  output logic [DATA_W/2-1:0]             mdio_wdata_o,
  input  logic                            mdio_ack_i,
  input  logic [DATA_W/2-1:0]             mdio_rdata_i,
  input  logic                            mdio_err_i
);
  localparam int HALF_W     = DATA_W / 2;
  localparam int WADDR_W    = PAGE_W + SEL_W + REG_W;
  localparam int SETTLE_CYC = PAGE_SETTLE_US * CLK_PER_US;
  localparam int GAP_CYC    = POLL_GAP_US * CLK_PER_US;
  localparam int MAX_CYC    = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LEN = CNT_W'(SETTLE_CYC);
  localparam logic [CNT_W-1:0] GAP_LEN    = CNT_W'(GAP_CYC);

  state_e state_q, state_d;
  op_e    op_q, cmd_op;

  logic [PAGE_W-1:0] page_q, page_c_q;
  logic              page_vld_q;
  logic [4:0]        phy_q;
  logic [REG_W-1:0]  reg_q;
  logic              hi_q, lo_first_q, err_q;
  logic [DATA_W-1:0] wdata_q, mask_q, set_q, rdata_q;
  logic [TMO_W-1:0]  tmo_q;

  logic [PAGE_W-1:0] am_page;
  logic [4:0]        am_phy;
  logic [REG_W-1:0]  am_reg;
  logic              cmd_hi, accept, need_page;
  logic [DATA_W-1:0] rd_word, merged;
  logic              poll_hit;
  logic              tmr_start, tmr_expired;
  logic [CNT_W-1:0]  tmr_len;

  assign cmd_op = op_e'(cmd_op_i);
  assign cmd_hi = (cmd_op == OP_RD16_HI) || (cmd_op == OP_WR16_HI);
  assign accept = cmd_valid_i && cmd_ready_o;

  mdio_addr_map #(
    .PAGE_W (PAGE_W),
    .SEL_W  (SEL_W),
    .REG_W  (REG_W)
  ) u_addr_map (
    .waddr_i (cmd_addr_i[WADDR_W:1]),
    .hi_i    (cmd_hi),
    .page_o  (am_page),
    .phy_o   (am_phy),
    .reg_o   (am_reg)
  );

  mdio_wait_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (tmr_start),
    .len_i     (tmr_len),
    .expired_o (tmr_expired)
  );

  function automatic state_e first_state(op_e op);
    case (op)
      OP_RD32, OP_RMW, OP_POLL: return S_RD0;
      OP_WR32:                  return S_WR0;
      OP_RD16_LO, OP_RD16_HI:   return S_RD16;
      default:                  return S_WR16;
    endcase
  endfunction

  assign need_page = !page_vld_q || (page_c_q != am_page);
  assign rd_word   = {mdio_rdata_i, rdata_q[HALF_W-1:0]};
  assign merged    = (rd_word & ~mask_q) | set_q;
  assign poll_hit  = ((rd_word & mask_q) == set_q);

  // Shared timer: page settle and poll gap never overlap
  always_comb begin
    tmr_start = 1'b0;
    tmr_len   = GAP_LEN;
    if (state_q == S_PAGE && mdio_ack_i) begin
      tmr_start = 1'b1;
      tmr_len   = SETTLE_LEN;
    end else if (state_q == S_RD1 && mdio_ack_i && op_q == OP_POLL &&
                 !poll_hit && tmo_q != '0) begin
      tmr_start = 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:   if (accept) state_d = need_page ? S_PAGE : first_state(cmd_op);
      S_PAGE:   if (mdio_ack_i) state_d = S_SETTLE;
      S_SETTLE: if (tmr_expired) state_d = first_state(op_q);
      S_RD0:    if (mdio_ack_i) state_d = S_RD1;
      S_RD1: if (mdio_ack_i) begin
        case (op_q)
          OP_RMW:  state_d = S_WR0;
          OP_POLL: state_d = (poll_hit || tmo_q == '0) ? S_RSP : S_GAP;
          default: state_d = S_RSP;
        endcase
      end
      S_GAP:    if (tmr_expired) state_d = S_RD0;
      S_WR0:    if (mdio_ack_i) state_d = S_WR1;
      S_WR1, S_WR16, S_RD16: if (mdio_ack_i) state_d = S_RSP;
      S_RSP:    state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      op_q       <= OP_RD32;
      page_q     <= '0;
      page_c_q   <= '0;
      page_vld_q <= 1'b0;
      phy_q      <= '0;
      reg_q      <= '0;
      hi_q       <= 1'b0;
      lo_first_q <= 1'b0;
      err_q      <= 1'b0;
      wdata_q    <= '0;
      mask_q     <= '0;
      set_q      <= '0;
      rdata_q    <= '0;
      tmo_q      <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q       <= cmd_op;
        page_q     <= am_page;
        phy_q      <= am_phy;
        reg_q      <= am_reg;
        hi_q       <= cmd_hi;
        lo_first_q <= lo_first_i;
        wdata_q    <= cmd_wdata_i;
        mask_q     <= cmd_mask_i;
        set_q      <= cmd_set_i;
        tmo_q      <= cmd_timeout_i;
        err_q      <= 1'b0;
        rdata_q    <= '0;
      end else begin
        if (mdio_ack_i && mdio_err_i) err_q <= 1'b1;
        if (state_q == S_SETTLE && tmr_expired) begin
          page_c_q   <= page_q;
          page_vld_q <= 1'b1;
        end
        if (mdio_ack_i) begin
          case (state_q)
            S_RD0:  rdata_q[HALF_W-1:0] <= mdio_rdata_i;
            S_RD16: rdata_q <= hi_q ? {mdio_rdata_i, {HALF_W{1'b0}}}
                                    : {{HALF_W{1'b0}}, mdio_rdata_i};
            S_RD1: begin
              rdata_q[DATA_W-1:HALF_W] <= mdio_rdata_i;
              if (op_q == OP_RMW) wdata_q <= merged;
              if (op_q == OP_POLL && !poll_hit) begin
                if (tmo_q == '0) err_q <= 1'b1;
                else             tmo_q <= tmo_q - 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // MDIO request fields follow the state; they cannot change before the acknowledge
  always_comb begin
    mdio_req_o   = 1'b0;
    mdio_we_o    = 1'b0;
    mdio_phy_o   = phy_q;
    mdio_reg_o   = reg_q;
    mdio_wdata_o = '0;
    case (state_q)
      S_PAGE: begin
        mdio_req_o   = 1'b1;
        mdio_we_o    = 1'b1;
        mdio_phy_o   = PAGE_PHY;
        mdio_reg_o   = '0;
        mdio_wdata_o = HALF_W'(page_q);
      end
      S_RD0, S_RD16: mdio_req_o = 1'b1;
      S_RD1: begin
        mdio_req_o = 1'b1;
        mdio_reg_o = reg_q + REG_W'(1);
      end
      S_WR0: begin
        mdio_req_o   = 1'b1;
        mdio_we_o    = 1'b1;
        mdio_reg_o   = lo_first_q ? reg_q : reg_q + REG_W'(1);
        mdio_wdata_o = lo_first_q ? wdata_q[HALF_W-1:0] : wdata_q[DATA_W-1:HALF_W];
      end
      S_WR1: begin
        mdio_req_o   = 1'b1;
        mdio_we_o    = 1'b1;
        mdio_reg_o   = lo_first_q ? reg_q + REG_W'(1) : reg_q;
        mdio_wdata_o = lo_first_q ? wdata_q[DATA_W-1:HALF_W] : wdata_q[HALF_W-1:0];
      end
      S_WR16: begin
        mdio_req_o   = 1'b1;
        mdio_we_o    = 1'b1;
        mdio_wdata_o = hi_q ? wdata_q[DATA_W-1:HALF_W] : wdata_q[HALF_W-1:0];
      end
      default: ;
    endcase
  end

  assign cmd_ready_o = (state_q == S_IDLE);
  assign rsp_valid_o = (state_q == S_RSP);
  assign rsp_rdata_o = rdata_q;
  assign rsp_err_o   = err_q;

  // R11
  accept_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !cmd_ready_o);
  // R11
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R11
  rsp_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !cmd_ready_o);
  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_req_o && !mdio_ack_i) |=> (mdio_req_o && $stable(mdio_phy_o) &&
      $stable(mdio_reg_o) && $stable(mdio_we_o) && $stable(mdio_wdata_o)));
  // R2
  page_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_req_o && mdio_phy_o == PAGE_PHY) |-> (mdio_we_o && mdio_reg_o == '0));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !mdio_req_o);
  // R4
  align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> !cmd_addr_i[0]);

endmodule

// File: tb/paged_mdio_seq_bench.sv
module paged_mdio_seq_bench;
  localparam int CPU = 2;
  localparam int SETTLE = 2000 * CPU;
  localparam int LAT = 3;

  localparam logic [2:0] RD32 = 3'd0, WR32 = 3'd1, RD16L = 3'd2, RD16H = 3'd3,
                         WR16L = 3'd4, WR16H = 3'd5, RMW = 3'd6, POLL = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        lo_first = 1'b1, cmd_valid = 1'b0, cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [17:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0, cmd_mask = '0, cmd_set = '0;
  logic [15:0] cmd_tmo = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        mreq, mwe, mack = 1'b0, merr = 1'b0;
  logic [4:0]  mphy, mreg;
  logic [15:0] mwdata, mrdata = '0;

  paged_mdio_seq #(.CLK_PER_US(CPU), .PAGE_SETTLE_US(2000), .POLL_GAP_US(1)) u_paged_mdio_seq (
    .clk_i(clk), .rst_ni(rst_n), .lo_first_i(lo_first),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .cmd_mask_i(cmd_mask),
    .cmd_set_i(cmd_set), .cmd_timeout_i(cmd_tmo),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .mdio_req_o(mreq), .mdio_we_o(mwe), .mdio_phy_o(mphy), .mdio_reg_o(mreg),
    .mdio_wdata_o(mwdata), .mdio_ack_i(mack), .mdio_rdata_i(mrdata), .mdio_err_i(merr));

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // switch register space model
  logic [15:0] mem [int];
  int  mpage = -1;
  int  flip_key = -1, flip_left = 0, err_key = -1, stable_bad = 0;
  logic [15:0] flip_val = '0;
  int  log_n = 0;
  logic        lg_we [32];
  logic [4:0]  lg_phy [32];
  logic [4:0]  lg_reg [32];
  logic [15:0] lg_dat [32];
  int          lg_ts [32];
  int          lg_ta [32];

  function automatic int key(input int pg, input int phy, input int rg);
    return pg * 1024 + phy * 32 + rg;
  endfunction

  function automatic logic [17:0] adr(input int pg, input int sel, input int rg);
    return 18'((pg << 9) | (sel << 6) | (rg << 1));
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (mreq && !mack) begin
        automatic logic we = mwe;
        automatic logic [4:0] ph = mphy, rg = mreg;
        automatic logic [15:0] wd = mwdata;
        automatic int ts = cyc;
        automatic int k;
        repeat (LAT) begin
          @(negedge clk);
          if (!mreq || mwe != we || mphy != ph || mreg != rg || mwdata != wd) stable_bad++;
        end
        k = key(mpage, int'(ph), int'(rg));
        merr = (k == err_key);
        if (we) begin
          if (ph == 5'h18 && rg == 5'd0) mpage = int'(wd);
          else mem[k] = wd;
          mrdata = '0;
        end else begin
          mrdata = mem.exists(k) ? mem[k] : 16'h0;
          if (k == flip_key && flip_left > 0) begin
            flip_left--;
            if (flip_left == 0) mem[k] = flip_val;
          end
        end
        if (log_n < 32) begin
          lg_we[log_n] = we; lg_phy[log_n] = ph; lg_reg[log_n] = rg;
          lg_dat[log_n] = we ? wd : mrdata; lg_ts[log_n] = ts; lg_ta[log_n] = cyc;
        end
        log_n++;
        mack = 1'b1;
        @(negedge clk);
        mack = 1'b0;
        merr = 1'b0;
      end
    end
  end

  task automatic run_cmd(input logic [2:0] op, input logic [17:0] a, input logic [31:0] wd,
                         input logic [31:0] mk, input logic [31:0] st, input logic [15:0] tmo,
                         output logic [31:0] rd, output logic er);
    int busy_bad = 0;
    @(negedge clk);
    log_n = 0;
    cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_mask = mk; cmd_set = st; cmd_tmo = tmo;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) begin
      if (cmd_ready) busy_bad++;
      @(negedge clk);
    end
    rd = rsp_rdata; er = rsp_err;
    chk(busy_bad == 0, "R11 ready low while busy", busy_bad, 0);
    @(negedge clk);
    chk(!rsp_valid && cmd_ready, "R11 one-cycle response", {rsp_valid, cmd_ready}, 2'b01);
  endtask

  task automatic chk_tr(input int i, input logic we, input logic [4:0] ph, input logic [4:0] rg,
                        input logic [15:0] d, input string rq);
    chk(lg_we[i] == we && lg_phy[i] == ph && lg_reg[i] == rg && lg_dat[i] == d, rq,
        {lg_we[i], 2'b0, lg_phy[i], 3'b0, lg_reg[i], lg_dat[i]}, {we, 2'b0, ph, 3'b0, rg, d});
  endtask

  task automatic t_reset();
    chk(cmd_ready && !rsp_valid && !mreq, "R1 reset state", {cmd_ready, rsp_valid, mreq}, 3'b100);
  endtask

  task automatic t_read_first();
    logic [31:0] rd; logic er;
    mem[key(0, 5'h12, 4)] = 16'hBEEF; mem[key(0, 5'h12, 5)] = 16'hDEAD;
    run_cmd(RD32, adr(0, 2, 4), 0, 0, 0, 0, rd, er);
    chk(log_n == 3, "R1 page 0 written on first access", log_n, 3);
    chk_tr(0, 1, 5'h18, 0, 16'h0000, "R2 page write");
    chk(lg_ts[1] - lg_ta[0] >= SETTLE, "R3 settle time", lg_ts[1] - lg_ta[0], SETTLE);
    chk_tr(1, 0, 5'h12, 4, 16'hBEEF, "R5 low half first (R4 phy)");
    chk_tr(2, 0, 5'h12, 5, 16'hDEAD, "R5 high half second");
    chk(rd == 32'hDEADBEEF && !er, "R5 read word", rd, 32'hDEADBEEF);
  endtask

  task automatic t_read_same_page();
    logic [31:0] rd; logic er;
    mem[key(0, 5'h15, 10)] = 16'h1234; mem[key(0, 5'h15, 11)] = 16'h5678;
    run_cmd(RD32, adr(0, 5, 10), 0, 0, 0, 0, rd, er);
    chk(log_n == 2, "R2 page write skipped", log_n, 2);
    chk_tr(0, 0, 5'h15, 10, 16'h1234, "R4 phy/reg mapping");
    chk(rd == 32'h56781234, "R5 read word", rd, 32'h56781234);
  endtask

  task automatic t_write_orders();
    logic [31:0] rd; logic er;
    lo_first = 1'b1;
    run_cmd(WR32, adr(3, 1, 2), 32'hCAFEF00D, 0, 0, 0, rd, er);
    chk(log_n == 3, "R2 new page written", log_n, 3);
    chk_tr(0, 1, 5'h18, 0, 16'h0003, "R2 page value");
    chk_tr(1, 1, 5'h11, 2, 16'hF00D, "R6 low-first: low to N");
    chk_tr(2, 1, 5'h11, 3, 16'hCAFE, "R6 low-first: high to N+1");
    lo_first = 1'b0;
    run_cmd(WR32, adr(3, 1, 6), 32'h01234567, 0, 0, 0, rd, er);
    chk(log_n == 2, "R6 two writes", log_n, 2);
    chk_tr(0, 1, 5'h11, 7, 16'h0123, "R6 high-first: high to N+1");
    chk_tr(1, 1, 5'h11, 6, 16'h4567, "R6 high-first: low to N");
    lo_first = 1'b1;
  endtask

  task automatic t_half();
    logic [31:0] rd; logic er;
    mem[key(3, 5'h11, 8)] = 16'hAAAA; mem[key(3, 5'h11, 9)] = 16'h5555;
    run_cmd(RD16L, adr(3, 1, 8), 0, 0, 0, 0, rd, er);
    chk(rd == 32'h0000AAAA && log_n == 1 && lg_reg[0] == 8, "R7 low read", rd, 32'h0000AAAA);
    run_cmd(RD16H, adr(3, 1, 8), 0, 0, 0, 0, rd, er);
    chk(rd == 32'h55550000 && log_n == 1 && lg_reg[0] == 9, "R7 high read", rd, 32'h55550000);
    run_cmd(WR16H, adr(3, 1, 8), 32'h98761234, 0, 0, 0, rd, er);
    chk_tr(0, 1, 5'h11, 9, 16'h9876, "R7 high write");
    run_cmd(WR16L, adr(3, 1, 8), 32'h98761234, 0, 0, 0, rd, er);
    chk_tr(0, 1, 5'h11, 8, 16'h1234, "R7 low write");
  endtask

  task automatic t_rmw();
    logic [31:0] rd; logic er;
    mem[key(3, 5'h11, 12)] = 16'hFF0F; mem[key(3, 5'h11, 13)] = 16'h00F0;
    run_cmd(RMW, adr(3, 1, 12), 0, 32'h0000FF00, 32'h00001200, 0, rd, er);
    chk(log_n == 4, "R8 transaction count", log_n, 4);
    chk_tr(2, 1, 5'h11, 12, 16'h120F, "R8 merged low");
    chk_tr(3, 1, 5'h11, 13, 16'h00F0, "R8 merged high");
  endtask

  task automatic t_poll_hit();
    logic [31:0] rd; logic er;
    mem[key(3, 5'h11, 14)] = 16'h0001; mem[key(3, 5'h11, 15)] = 16'h0000;
    flip_key = key(3, 5'h11, 15); flip_left = 3; flip_val = 16'hA500;
    run_cmd(POLL, adr(3, 1, 14), 0, 32'hFF000000, 32'hA5000000, 16'd10, rd, er);
    chk(!er && rd == 32'hA5000001, "R9 poll match", {er, rd[30:0]}, 32'hA5000001);
    chk(log_n == 8, "R9 four attempts", log_n, 8);
    chk(lg_ts[2] - lg_ta[1] >= CPU, "R9 retry gap", lg_ts[2] - lg_ta[1], CPU);
    flip_key = -1;
  endtask

  task automatic t_poll_timeout();
    logic [31:0] rd; logic er;
    run_cmd(POLL, adr(3, 1, 14), 0, 32'hFF000000, 32'h5A000000, 16'd2, rd, er);
    chk(er, "R10 timeout error", er, 1);
    chk(log_n == 6, "R10 T+1 attempts", log_n, 6);
  endtask

  task automatic t_err();
    logic [31:0] rd; logic er;
    err_key = key(3, 5'h11, 3);
    run_cmd(WR32, adr(3, 1, 2), 32'h11112222, 0, 0, 0, rd, er);
    chk(er, "R13 error on second half", er, 1);
    err_key = -1;
    run_cmd(RD32, adr(3, 1, 2), 0, 0, 0, 0, rd, er);
    chk(!er && rd == 32'h11112222, "R13 error clears", {er, rd[30:0]}, 32'h11112222);
  endtask

  task automatic t_page_back();
    logic [31:0] rd; logic er;
    run_cmd(RD32, adr(0, 2, 4), 0, 0, 0, 0, rd, er);
    chk(log_n == 3, "R2 page change rewrites", log_n, 3);
    chk_tr(0, 1, 5'h18, 0, 16'h0000, "R2 page 0 value");
    chk(rd == 32'hDEADBEEF, "R5 read after page change", rd, 32'hDEADBEEF);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_first();
    t_read_same_page();
    t_write_orders();
    t_half();
    t_rmw();
    t_poll_hit();
    t_poll_timeout();
    t_err();
    t_page_back();
    chk(stable_bad == 0, "R12 request held until acknowledge", stable_bad, 0);
    finish_run();
  end

endmodule